// File: doc/BRIEF.md
# Conversion Sequencer and Status Logic for a Successive-Approximation ADC

This block is the digital control around an external successive-approximation converter core. A CPU reaches it over a small read/write bus with two addresses: a control/status register at address 0 and a result register at address 1. Any write to the control register starts a conversion on the chosen channel, or halts the converter when the power-down channel code is written. A conversion is started by a one-cycle start pulse that carries the channel number. The core answers with a one-cycle done pulse and an 8-bit result, which the block latches into the result register.

Bit 7 of the control register has two meanings. With interrupts disabled it reads back as a conversion-complete flag. With interrupts enabled it selects whether each completed conversion raises the CPU request or the DMA request. Conversions run once per write in single mode, or back to back in continuous mode. In wait mode the block keeps converting, and a CPU request also drives a wake output. In stop mode the block aborts any conversion in progress. After stop ends, one settling conversion is run and its result is thrown away.

Top module: `adc_seq`

## Requirements
- R1: After reset, the control register reads 8'h1F: channel field at bits [4:0] set to 31, continuous bit [5] = 0, interrupt-enable bit [6] = 0, shared bit [7] = 0. The result register reads 0, no start pulse is issued and both requests are low.
- R2: A control write (address 0) with a channel other than 31 issues one start pulse, one cycle wide, carrying the channel. In single mode (bit 5 = 0), exactly one conversion runs and the block then stays idle.
- R3: Each completed conversion loads the core result into the result register (address 1). In continuous mode conversions repeat, and each one overwrites the register whether or not it was read.
- R4: With bit 6 = 0, bit 7 reads 1 from the first completed conversion onward. It stays 1 through later conversions until the result register is read or the control register is written.
- R5: With bit 6 = 1, every completed conversion raises cpuIrq if bit 7 = 0 or dmaIrq if bit 7 = 1, and bit 7 reads back the written selector. A request is a level that clears on a result read or a control write.
- R6: A control write aborts a conversion in progress. Its result is never loaded, even if its done pulse arrives in the same cycle as the write.
- R7: Channel code 31 is power-down. While it is selected no start pulse is issued.
- R8: While waitMode is high, conversions proceed as normal and wakeReq follows cpuIrq. A DMA request does not wake.
- R9: While stopMode is high no start is issued and no result is loaded. When stop ends after an interrupted or continuous run, one settling conversion runs and is discarded, and then conversions resume.
- R10: If a result read and a result load fall in the same cycle, the read returns the old value, and afterwards the new value is stored and the flag is set.
- R11: Writes to address 1 have no effect on the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 1 | 0 = control/status, 1 = result |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data (combinational) |
| coreStart | output | 1 | One-cycle conversion start to core |
| coreChan | output | 5 | Channel for the core |
| coreDone | input | 1 | One-cycle completion from core |
| coreResult | input | 8 | Conversion result, valid with coreDone |
| waitMode | input | 1 | Wait low-power state |
| stopMode | input | 1 | Stop low-power state |
| cpuIrq | output | 1 | CPU interrupt request level |
| dmaIrq | output | 1 | DMA request level |
| wakeReq | output | 1 | Wake request during wait |

## Verification
Two pairs of events can land in the same cycle. In the first, a result load from the core's done pulse meets a CPU read of the result register. In the second, a done pulse meets a control write that must abort it. The bench counts edges from the write to the exact cycle in which the modelled core raises done, and places the read or the write there. For the read, it judges that the returned data is the old value, that the new value is stored and that the flag ends set. For the write, it judges that the result register is unchanged and that no request appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_START, SEQ_BUSY} seqState_t;

  typedef struct packed {
    logic ctrlWr;
    logic dataRd;
    logic load;
  } seqStrobes_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataRd,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              contMode,
  input  logic              stopMode,
  input  logic              coreDone,
  output logic              coreStart,
  output seqStrobes_t       strobes
);
  localparam logic [CHAN_W-1:0] PWR_DOWN = '1;

  seqState_t state;
  logic settle;
  logic resumePend;
  logic stopQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      settle     <= 1'b0;
      resumePend <= 1'b0;
      stopQ      <= 1'b0;
    end else begin
      stopQ <= stopMode;
      if (stopMode) begin
        state  <= SEQ_IDLE;
        settle <= 1'b0;
        if (ctrlWr)
          resumePend <= (wrChan != PWR_DOWN);
        else if (state != SEQ_IDLE || (contMode && chanSel != PWR_DOWN))
          resumePend <= 1'b1;
      end else if (ctrlWr) begin
        state      <= (wrChan != PWR_DOWN) ? SEQ_START : SEQ_IDLE;
        settle     <= 1'b0;
        resumePend <= 1'b0;
      end else if (stopQ) begin
        if (resumePend) begin
          state  <= SEQ_START;
          settle <= 1'b1;
        end
        resumePend <= 1'b0;
      end else begin
        case (state)
          SEQ_START: state <= SEQ_BUSY;
          SEQ_BUSY: if (coreDone) begin
            if (settle) begin
              settle <= 1'b0;
              state  <= SEQ_START;
            end else begin
              state <= (contMode && chanSel != PWR_DOWN) ? SEQ_START : SEQ_IDLE;
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    coreStart      = (state == SEQ_START) && !stopMode && !ctrlWr;
    strobes.ctrlWr = ctrlWr;
    strobes.dataRd = dataRd;
    strobes.load   = (state == SEQ_BUSY) && coreDone && !settle && !ctrlWr && !stopMode;
  end
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] coreResult,
  output logic [CHAN_W-1:0] chanSel,
  output logic              contMode,
  output logic              irqEn,
  output logic              sharedRd,
  output logic              dmaSel,
  output logic              irqPend,
  output logic [DATA_W-1:0] dataVal
);
  localparam int CTRL_W = CHAN_W + 3;

  logic [CTRL_W-1:0] ctrlReg;
  logic doneFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= CTRL_W'({CHAN_W{1'b1}});
      dataVal  <= '0;
      doneFlag <= 1'b0;
      irqPend  <= 1'b0;
    end else if (strobes.ctrlWr) begin
      ctrlReg  <= wrData[CTRL_W-1:0];
      doneFlag <= 1'b0;
      irqPend  <= 1'b0;
    end else if (strobes.load) begin
      dataVal  <= coreResult;
      doneFlag <= 1'b1;
      irqPend  <= irqEn;
    end else if (strobes.dataRd) begin
      doneFlag <= 1'b0;
      irqPend  <= 1'b0;
    end
  end

  always_comb begin
    chanSel  = ctrlReg[CHAN_W-1:0];
    contMode = ctrlReg[CHAN_W];
    irqEn    = ctrlReg[CHAN_W+1];
    dmaSel   = ctrlReg[CHAN_W+2];
    sharedRd = irqEn ? dmaSel : doneFlag;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              coreStart,
  output logic [CHAN_W-1:0] coreChan,
  input  logic              coreDone,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              waitMode,
  input  logic              stopMode,
  output logic              cpuIrq,
  output logic              dmaIrq,
  output logic              wakeReq
);
  seqStrobes_t strobes;
  logic [CHAN_W-1:0] chanSel;
  logic [DATA_W-1:0] dataVal;
  logic contMode, irqEn, sharedRd, dmaSel, irqPend;
  logic ctrlWr, dataRd;

  assign ctrlWr = wrEn && !addr;
  assign dataRd = rdEn && addr;

  adc_seq_ctrl #(.CHAN_W(CHAN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataRd(dataRd),
    .wrChan(wrData[CHAN_W-1:0]), .chanSel(chanSel), .contMode(contMode),
    .stopMode(stopMode), .coreDone(coreDone), .coreStart(coreStart),
    .strobes(strobes)
  );

  adc_seq_dp #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .coreResult(coreResult), .chanSel(chanSel), .contMode(contMode),
    .irqEn(irqEn), .sharedRd(sharedRd), .dmaSel(dmaSel),
    .irqPend(irqPend), .dataVal(dataVal)
  );

  always_comb begin
    coreChan = chanSel;
    cpuIrq   = irqPend && !dmaSel;
    dmaIrq   = irqPend && dmaSel;
    wakeReq  = waitMode && cpuIrq;
    rdData   = addr ? dataVal : DATA_W'({sharedRd, irqEn, contMode, chanSel});
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              addr,
  input logic              coreStart,
  input logic              coreDone,
  input logic              stopMode,
  input logic              cpuIrq,
  input logic              dmaIrq,
  input logic [CHAN_W-1:0] chanSel,
  input logic [DATA_W-1:0] dataVal
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN) coreStart |=> !coreStart); // R2
  AST_DATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN) !coreDone |=> $stable(dataVal)); // R3
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(cpuIrq && dmaIrq)); // R5
  AST_WRITE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rstN) (wrEn && !addr) |=> (!cpuIrq && !dmaIrq)); // R5
  AST_PWRDN_NO_START: assert property (@(posedge clk) disable iff (!rstN) (chanSel == '1) |-> !coreStart); // R7
  AST_STOP_NO_START: assert property (@(posedge clk) disable iff (!rstN) stopMode |-> !coreStart); // R9
endmodule

bind adc_seq adc_seq_chk #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .coreStart(coreStart),
  .coreDone(coreDone), .stopMode(stopMode), .cpuIrq(cpuIrq), .dmaIrq(dmaIrq),
  .chanSel(chanSel), .dataVal(dataVal)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic coreStart, coreDone;
  logic [4:0] coreChan;
  logic [7:0] coreResult;
  logic waitMode = 1'b0, stopMode = 1'b0;
  logic cpuIrq, dmaIrq, wakeReq;

  int checks = 0, errors = 0;
  int cnt = 0;
  int startCount = 0, doneCount = 0;
  logic [4:0] chanQ = '0;
  logic [7:0] lastRes = '0;

  typedef struct { logic [7:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  adc_seq u_adc_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .coreStart(coreStart), .coreChan(coreChan),
    .coreDone(coreDone), .coreResult(coreResult), .waitMode(waitMode),
    .stopMode(stopMode), .cpuIrq(cpuIrq), .dmaIrq(dmaIrq), .wakeReq(wakeReq)
  );

  // fixed-latency core model; a new start supersedes an old one
  assign coreDone   = (cnt == 1);
  assign coreResult = {chanQ[3:0], 4'(startCount)};

  always @(posedge clk) begin
    if (coreStart) begin
      cnt        <= LAT;
      chanQ      <= coreChan;
      startCount <= startCount + 1;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
    end
    if (coreDone) begin
      doneCount <= doneCount + 1;
      lastRes   <= coreResult;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitDone(input int n);
    int target = doneCount + n;
    while (doneCount < target) @(negedge clk);
  endtask

  task automatic pushExp(input logic [7:0] v, input string tag);
    expItem_t it;
    it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic popCheck();
    logic [7:0] d;
    expItem_t it;
    busRead(1'b1, d);
    it = expQ.pop_front();
    check(d == it.val, it.tag, d, it.val);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, base;
    int s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(1'b0, d);
    check(d == 8'h1F, "R1 ctrl reset", d, 8'h1F);
    pushExp(8'h00, "R1 data reset");
    popCheck();
    check(!cpuIrq && !dmaIrq && startCount == 0, "R1 idle outputs", startCount, 0);

    // R2 single conversion, R4 flag
    s0 = startCount;
    busWrite(1'b0, 8'h03);
    waitDone(1);
    repeat (20) @(negedge clk);
    check(startCount - s0 == 1, "R2 single start count", startCount - s0, 1);
    check(chanQ == 5'd3, "R2 channel", chanQ, 3);
    busRead(1'b0, d);
    check(d == 8'h83, "R4 flag set", d, 8'h83);
    pushExp(lastRes, "R3 single result");
    popCheck();
    busRead(1'b0, d);
    check(d == 8'h03, "R4 flag cleared by read", d, 8'h03);

    // R11 write to result address ignored
    busWrite(1'b1, 8'h55);
    pushExp(lastRes, "R11 data write ignored");
    popCheck();

    // R5 CPU request
    busWrite(1'b0, 8'h45);
    waitDone(1);
    check(cpuIrq && !dmaIrq, "R5 cpu request", {cpuIrq, dmaIrq}, 2'b10);
    busRead(1'b0, d);
    check(d == 8'h45, "R5 selector readback", d, 8'h45);
    pushExp(lastRes, "R5 result");
    popCheck();
    check(!cpuIrq, "R5 cleared by read", cpuIrq, 0);

    // R5 DMA request, then R7 power-down
    busWrite(1'b0, 8'hC5);
    waitDone(1);
    check(dmaIrq && !cpuIrq, "R5 dma request", {cpuIrq, dmaIrq}, 2'b01);
    busWrite(1'b0, 8'h1F);
    check(!dmaIrq && !cpuIrq, "R5 cleared by write", dmaIrq, 0);
    s0 = startCount;
    repeat (40) @(negedge clk);
    check(startCount == s0, "R7 no starts when powered down", startCount - s0, 0);

    // R3 continuous overwrite, R4 flag persistence
    busWrite(1'b0, 8'h22);
    waitDone(1);
    pushExp(lastRes, "R3 first continuous");
    popCheck();
    waitDone(2);
    busRead(1'b0, d);
    check(d == 8'hA2, "R4 flag held across conversions", d, 8'hA2);
    pushExp(lastRes, "R3 overwrite latest");
    popCheck();
    busRead(1'b0, d);
    check(d == 8'h22, "R4 flag cleared in continuous", d, 8'h22);
    waitDone(1);
    busRead(1'b0, d);
    check(d == 8'hA2, "R3 continuous keeps running", d, 8'hA2);
    busWrite(1'b0, 8'h02);
    waitDone(1);
    s0 = startCount;
    repeat (20) @(negedge clk);
    check(startCount == s0, "R3 stops when continuous bit cleared", startCount - s0, 0);

    // R8 wait mode
    waitMode = 1'b1;
    busWrite(1'b0, 8'h42);
    waitDone(1);
    check(wakeReq == 1'b1, "R8 wake on cpu request", wakeReq, 1);
    busWrite(1'b0, 8'hC2);
    waitDone(1);
    check(wakeReq == 1'b0 && dmaIrq, "R8 no wake on dma", wakeReq, 0);
    waitMode = 1'b0;

    // R6 abort coinciding with done pulse
    busWrite(1'b0, 8'h07);
    waitDone(1);
    base = lastRes;
    busWrite(1'b0, 8'h07);
    repeat (LAT) @(negedge clk);
    busWrite(1'b0, 8'h08);
    pushExp(base, "R6 aborted result not loaded");
    popCheck();
    check(!cpuIrq && !dmaIrq, "R6 no request", cpuIrq, 0);
    waitDone(1);
    pushExp(lastRes, "R6 following result loaded");
    popCheck();

    // R10 read and load in the same cycle
    base = lastRes;
    busWrite(1'b0, 8'h09);
    repeat (LAT) @(negedge clk);
    busRead(1'b1, d);
    check(d == base, "R10 read returns old data", d, base);
    busRead(1'b0, d);
    check(d == 8'h89, "R10 flag set after collision", d, 8'h89);
    pushExp(lastRes, "R10 new data stored");
    popCheck();

    // R9 stop mode
    busWrite(1'b0, 8'h23);
    waitDone(1);
    busRead(1'b1, base);
    repeat (2) @(negedge clk);
    stopMode = 1'b1;
    s0 = startCount;
    repeat (20) @(negedge clk);
    check(startCount == s0, "R9 no starts in stop", startCount - s0, 0);
    pushExp(base, "R9 aborted result discarded");
    popCheck();
    stopMode = 1'b0;
    waitDone(1);
    pushExp(base, "R9 settling result discarded");
    popCheck();
    waitDone(1);
    check(lastRes != base, "R9 resumed result differs", lastRes, base);
    pushExp(lastRes, "R9 resumed result loaded");
    popCheck();
    busWrite(1'b0, 8'h1F);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule